// File: doc/BRIEF.md
# Card Host Interrupt Status Unit

This unit keeps the interrupt state of a memory-card host controller. Event pulses from the command, data and card-detect logic set bits in a 32-bit raw status word. Software reads that word and clears bits by writing ones. A mask register selects which raw bits can raise the interrupt. A control word carries a global interrupt enable. A status register holds a card-present flag that follows insertion and removal.

The register port is one 32-bit word. Reads are combinational from `reg_addr_i`. Writes take effect on the clock edge where `reg_we_i` is high. The single level interrupt `irq_o` comes from a flop, so it follows the register state one cycle later.

Top module: `card_irq_unit`

## Requirements
- R1: Each event input sets one raw status bit on the next clock edge. The mapping is `evt_i[0]` no response to bit 1, `evt_i[1]` command done to bit 2, `evt_i[2]` data done to bit 3, `evt_i[3]` auto-stop done to bit 14, `evt_i[4]` SDIO to bit 16, `evt_i[5]` card insert to bit 30, and `evt_i[6]` card remove to bit 31.
- R2: `irq_o` is high only when control bit 4 is set and at least one raw bit is set whose mask bit is also set. It is low whenever control bit 4 is clear.
- R3: A read of the masked status address returns the raw word ANDed with the mask. The mask resets to zero and is stored exactly as written.
- R4: A write to either the raw status address or the masked status address clears every raw bit where the write data has a one. It leaves all other raw bits unchanged.
- R5: The status register reads 0x100 after reset, with bit 8 as the card-present flag. A write with data bit 8 set clears the flag. A write with bit 8 clear leaves it unchanged.
- R6: The control word resets to 0x300. A write stores the data, but bits 2, 1 and 0 always read back as zero.
- R7: A card insertion sets raw bit 30, clears raw bit 31 and sets the present flag. A removal sets raw bit 31, clears raw bit 30 and clears the present flag.
- R8: When an event and a software clear hit the same raw bit in the same cycle, the bit ends up set.
- R9: `irq_o` changes one clock after the register state that causes it. It does not change in the same cycle as that state.
- R10: The byte offsets are control 0x00, mask 0x04, masked status 0x08, raw status 0x0C and status 0x10. A read of any other offset returns zero, and a write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | ADDR_W | Byte offset for both read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| evt_i | input | 7 | Single-cycle event pulses, mapped as in R1 |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
The assertions assume that card insert and card remove are never high in the same cycle. They also assume that each event is a single-cycle pulse from logic that is out of reset. The bench drives at most one card event per pulse and always drops the events after one clock. Under this assumption, raw bits 30 and 31 can never be set together. The bench exercises set-against-clear collisions only on bits that are not card bits. It holds the register write strobe for exactly one edge per access.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned N_EVT = 7;

  localparam int unsigned BIT_INS = 30;
  localparam int unsigned BIT_REM = 31;
  localparam int unsigned BIT_PRESENT = 8;

  localparam int unsigned EVT_INS = 5;
  localparam int unsigned EVT_REM = 6;

  localparam logic [DW-1:0] CTRL_RST   = 32'h0000_0300;
  localparam logic [DW-1:0] CTRL_WMASK = 32'hFFFF_FFF8;
  localparam int unsigned   CTRL_IE    = 4;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MASK = 8'h04;
  localparam logic [7:0] OFS_MSTS = 8'h08;
  localparam logic [7:0] OFS_RAW  = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;

  function automatic int unsigned evt_pos(int unsigned idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      3:       return 14;
      4:       return 16;
      5:       return BIT_INS;
      default: return BIT_REM;
    endcase
  endfunction
endpackage

// File: rtl/card_irq_raw.sv
module card_irq_raw
  import card_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] sw_clr_i,
  input  logic          card_in_i,
  input  logic          card_out_i,
  input  logic          present_clr_i,
  output logic [DW-1:0] raw_o,
  output logic          present_o
);
  logic [DW-1:0] raw_q;
  logic [DW-1:0] hw_clr;
  logic          present_q;

  always_comb begin
    hw_clr = '0;
    hw_clr[BIT_REM] = card_in_i;
    hw_clr[BIT_INS] = card_out_i;
  end

  // per-bit register: set beats any clear
  for (genvar b = 0; b < DW; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   raw_q[b] <= 1'b0;
      else if (set_i[b])             raw_q[b] <= 1'b1;
      else if (sw_clr_i[b] || hw_clr[b]) raw_q[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            present_q <= 1'b1;
    else if (card_in_i)     present_q <= 1'b1;
    else if (card_out_i)    present_q <= 1'b0;
    else if (present_clr_i) present_q <= 1'b0;
  end

  assign raw_o     = raw_q;
  assign present_o = present_q;

  AST_CARD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(raw_q[BIT_INS] && raw_q[BIT_REM])); // R7
  AST_PRESENT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_in_i |=> present_q); // R7
  AST_PRESENT_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_out_i |=> !present_q); // R7
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((raw_q & $past(set_i)) == $past(set_i))); // R8
endmodule

// File: rtl/card_irq_cfg.sv
module card_irq_cfg
  import card_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] mask_o
);
  logic [DW-1:0] ctrl_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      mask_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= wdata_i & CTRL_WMASK; // reset-trigger bits self-clear
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/card_irq_out.sv
module card_irq_out
  import card_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] raw_i,
  input  logic [DW-1:0] mask_i,
  output logic          irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_i && ((raw_i & mask_i) != '0);
  end

  assign irq_o = irq_q;

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o); // R2
  AST_IRQ_NOSRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_i & mask_i) == '0) |=> !irq_o); // R2
endmodule

// File: rtl/card_irq_unit.sv
module card_irq_unit
  import card_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [N_EVT-1:0]  evt_i,
  output logic              irq_o
);
  logic [DW-1:0] set_vec, clr_vec, raw, ctrl, mask;
  logic          present;
  logic          hit_ctrl, hit_mask, hit_msts, hit_raw, hit_stat;

  assign hit_ctrl = reg_addr_i == ADDR_W'(OFS_CTRL);
  assign hit_mask = reg_addr_i == ADDR_W'(OFS_MASK);
  assign hit_msts = reg_addr_i == ADDR_W'(OFS_MSTS);
  assign hit_raw  = reg_addr_i == ADDR_W'(OFS_RAW);
  assign hit_stat = reg_addr_i == ADDR_W'(OFS_STAT);

  always_comb begin
    set_vec = '0;
    for (int unsigned i = 0; i < N_EVT; i++) set_vec[evt_pos(i)] = evt_i[i];
  end

  assign clr_vec = (reg_we_i && (hit_raw || hit_msts)) ? reg_wdata_i : '0;

  card_irq_raw i_raw (
    .clk_i,
    .rst_ni,
    .set_i        (set_vec),
    .sw_clr_i     (clr_vec),
    .card_in_i    (evt_i[EVT_INS]),
    .card_out_i   (evt_i[EVT_REM]),
    .present_clr_i(reg_we_i && hit_stat && reg_wdata_i[BIT_PRESENT]),
    .raw_o        (raw),
    .present_o    (present)
  );

  card_irq_cfg i_cfg (
    .clk_i,
    .rst_ni,
    .ctrl_we_i(reg_we_i && hit_ctrl),
    .mask_we_i(reg_we_i && hit_mask),
    .wdata_i  (reg_wdata_i),
    .ctrl_o   (ctrl),
    .mask_o   (mask)
  );

  card_irq_out i_out (
    .clk_i,
    .rst_ni,
    .en_i  (ctrl[CTRL_IE]),
    .raw_i (raw),
    .mask_i(mask),
    .irq_o
  );

  always_comb begin
    reg_rdata_o = '0;
    if (hit_ctrl) reg_rdata_o = ctrl;
    if (hit_mask) reg_rdata_o = mask;
    if (hit_msts) reg_rdata_o = raw & mask;
    if (hit_raw)  reg_rdata_o = raw;
    if (hit_stat) reg_rdata_o[BIT_PRESENT] = present;
  end

  AST_CTRL_SELFCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_ctrl |-> (reg_rdata_o[2:0] == 3'b000)); // R6
  AST_CARD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_i[EVT_INS], evt_i[EVT_REM]})); // R7
endmodule

// File: tb/test_card_irq_unit.sv
module test_card_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  evt = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  card_irq_unit i_card_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  // monitor: compares on the falling edge, away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk) #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk) #1;
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(posedge clk) #1;
    evt = e;
    @(posedge clk) #1;
    evt = '0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk) #1;
    addr = a;
    sb_q.push_back('{is_irq: 1'b0, exp: e, tag: tag});
    @(negedge clk);
  endtask

  task automatic exp_irq_now(input logic e, input string tag);
    sb_q.push_back('{is_irq: 1'b1, exp: {31'b0, e}, tag: tag});
    @(negedge clk);
  endtask

  task automatic exp_irq(input logic e, input string tag);
    @(posedge clk) #1;
    exp_irq_now(e, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state
    exp_rd(8'h00, 32'h300, "R6 ctrl reset");
    exp_rd(8'h0C, 32'h0,   "R1 raw reset");
    exp_rd(8'h04, 32'h0,   "R3 mask reset");
    exp_rd(8'h10, 32'h100, "R5 status reset");
    exp_irq(1'b0, "R2 irq reset");
    // events set bits
    pulse(7'b0000010);
    exp_rd(8'h0C, 32'h4, "R1 cmd done bit 2");
    exp_irq(1'b0, "R2 masked off");
    pulse(7'b0010000);
    exp_rd(8'h0C, 32'h0001_0004, "R1 sdio bit 16");
    wr(8'h04, 32'h4);
    exp_rd(8'h08, 32'h4, "R3 masked read");
    exp_rd(8'h04, 32'h4, "R3 mask readback");
    exp_irq(1'b0, "R2 enable clear");
    // enable, self-clearing control bits, registered irq
    wr(8'h00, 32'h317);
    exp_irq_now(1'b0, "R9 irq lags state");
    exp_irq(1'b1, "R9 irq after one cycle");
    exp_rd(8'h00, 32'h310, "R6 low bits read zero");
    // clear via masked address
    wr(8'h08, 32'h4);
    exp_rd(8'h0C, 32'h0001_0000, "R4 clear via masked addr");
    exp_irq(1'b0, "R2 no source");
    wr(8'h0C, 32'h0001_0000);
    // clear via raw address, partial
    pulse(7'b0000101);
    exp_rd(8'h0C, 32'hA, "R1 no-resp and data done");
    wr(8'h0C, 32'h2);
    exp_rd(8'h0C, 32'h8, "R4 clear only ones");
    wr(8'h0C, 32'h8);
    // card events
    pulse(7'b1000000);
    exp_rd(8'h0C, 32'h8000_0000, "R7 remove sets 31");
    exp_rd(8'h10, 32'h0, "R7 remove clears present");
    pulse(7'b0100000);
    exp_rd(8'h0C, 32'h4000_0000, "R7 insert sets 30 clears 31");
    exp_rd(8'h10, 32'h100, "R7 insert sets present");
    // status write-one-clear
    wr(8'h10, 32'h0);
    exp_rd(8'h10, 32'h100, "R5 zero write keeps");
    wr(8'h10, 32'h100);
    exp_rd(8'h10, 32'h0, "R5 one write clears");
    // set beats clear
    @(posedge clk) #1;
    we = 1'b1; addr = 8'h0C; wdata = 32'hFFFF_FFFF; evt = 7'b0001000;
    @(posedge clk) #1;
    we = 1'b0; addr = '0; wdata = '0; evt = '0;
    exp_rd(8'h0C, 32'h0000_4000, "R8 set wins");
    // masked interrupt with global enable toggled
    wr(8'h04, 32'h4000);
    exp_irq(1'b1, "R2 mask and enable");
    wr(8'h00, 32'h0);
    exp_irq(1'b0, "R2 enable off");
    // unmapped offsets
    wr(8'h20, 32'hFFFF_FFFF);
    exp_rd(8'h20, 32'h0, "R10 unmapped read");
    exp_rd(8'h0C, 32'h0000_4000, "R10 unmapped write no effect");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule